// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Halfway Interrupt

This block keeps the bookkeeping of one DMA channel while it moves data. Software, or a channel setup path, loads it with a number of transfer units, a source address, a destination address, a unit size and a stepping rule for each address. The bus side then pulses a grant input once for every unit it has moved. On every such grant the block counts one unit off the remaining total and steps both addresses by the unit size.

Two sticky interrupt flags report progress. One rises when half of the programmed units are done, the other when the last unit is done. Each flag has its own enable and its own write-one-to-clear input. The final grant also produces a one-cycle end pulse that the channel arbiter uses to retire the channel. Bus cycles and data buffering are handled elsewhere.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset `busy`, `remaining`, both addresses, `xfer_end`, both flags and both interrupt outputs are zero.
- R2: A `load` pulse captures count, addresses, unit size and address modes, and sets `busy` at the next clock edge.
- R3: A `grant` while `busy` and without `load` lowers `remaining` by one at the next edge; a `grant` while idle changes neither `remaining` nor the addresses.
- R4: On each accepted grant, an address in mode 1 rises and an address in mode 2 falls by the unit size. Modes 0 and 3 leave it unchanged. Unit codes 0, 1, 2 and 3 mean 1, 2, 4 and 16 bytes, and addresses wrap modulo 2^32.
- R5: A loaded count of zero means 16,777,216 units. `remaining` reads 0 until the first grant and then 24'hFFFFFF, and `busy` stays set.
- R6: The halfway flag sets once per loaded run, on the grant that makes the remaining units equal the loaded total divided by two and rounded down. A total of one unit sets it on the final grant.
- R7: The grant that brings the remaining units to zero sets the done flag, clears `busy`, and raises `xfer_end` for exactly one cycle.
- R8: A flag stays set until its clear input is high at a clock edge. When a set and a clear happen in the same cycle, the set wins.
- R9: `irq_half` and `irq_done` equal their flag ANDed with the matching enable. A disabled flag is still held.
- R10: When `load` and `grant` are high in the same cycle, the load takes effect and the grant is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start a new run with the load_* values |
| load_count | input | 24 | Units to transfer; 0 means 2^24 |
| load_src | input | 32 | Initial source address |
| load_dst | input | 32 | Initial destination address |
| load_unit | input | 2 | Unit size code: 0=1, 1=2, 2=4, 3=16 bytes |
| src_mode | input | 2 | Source stepping: 0 hold, 1 up, 2 down, 3 hold |
| dst_mode | input | 2 | Destination stepping, same codes |
| grant | input | 1 | One unit has been transferred |
| half_ie | input | 1 | Enable for the halfway interrupt |
| done_ie | input | 1 | Enable for the completion interrupt |
| half_clr | input | 1 | Write-one-to-clear for the halfway flag |
| done_clr | input | 1 | Write-one-to-clear for the done flag |
| busy | output | 1 | Run in progress |
| remaining | output | 24 | Units still to transfer |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| xfer_end | output | 1 | One-cycle pulse after the final unit |
| half_flag | output | 1 | Sticky halfway flag |
| done_flag | output | 1 | Sticky completion flag |
| irq_half | output | 1 | Halfway interrupt request |
| irq_done | output | 1 | Completion interrupt request |

## Verification
On every cycle the assertions check the one-unit decrement, that the count and addresses stay frozen when no grant is accepted, that a held address never moves, that the end pulse and the drop of busy follow the last unit, and that flags are sticky and a set beats a clear. Other behaviour can only be shown by the bench's scenarios, because it depends on the history of the whole run. This covers the exact grant that reaches the halfway point, the single firing per run, the zero-means-maximum count, address wraparound and the load-over-grant priority. A reference model in the bench follows random loads, grants, clears and enable changes cycle by cycle.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int CNT_W  = 24;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {UNIT_B = 2'd0, UNIT_W = 2'd1, UNIT_L = 2'd2, UNIT_Q = 2'd3} unit_e;
  typedef enum logic [1:0] {AM_HOLD = 2'd0, AM_UP = 2'd1, AM_DOWN = 2'd2, AM_RSVD = 2'd3} amode_e;

  // bytes moved per unit
  function automatic logic [ADDR_W-1:0] unit_bytes(unit_e u);
    case (u)
      UNIT_B:  return ADDR_W'(1);
      UNIT_W:  return ADDR_W'(2);
      UNIT_L:  return ADDR_W'(4);
      default: return ADDR_W'(16);
    endcase
  endfunction

  // address after one unit, wrapping modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] addr_next(logic [ADDR_W-1:0] a, amode_e m, unit_e u);
    case (m)
      AM_UP:   return a + unit_bytes(u);
      AM_DOWN: return a - unit_bytes(u);
      default: return a;
    endcase
  endfunction

  // remaining-count value at which the run is half done; 0 encodes 2^CNT_W
  function automatic logic [CNT_W-1:0] half_point(logic [CNT_W-1:0] n);
    if (n == '0) return {1'b1, {(CNT_W-1){1'b0}}};
    return n >> 1;
  endfunction
endpackage

// File: rtl/xfc_addr_step.sv
module xfc_addr_step
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [1:0]        init_mode,
  input  logic [1:0]        init_unit,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;
  amode_e            mode_q;
  unit_e             unit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= AM_HOLD;
      unit_q <= UNIT_B;
    end else if (load) begin
      addr_q <= init_addr;
      mode_q <= amode_e'(init_mode);
      unit_q <= unit_e'(init_unit);
    end else if (adv) begin
      addr_q <= addr_next(addr_q, mode_q, unit_q);
    end
  end

  assign addr = addr_q;

  // R4: a held address never moves on a grant
  p_hold_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && (mode_q == AM_HOLD || mode_q == AM_RSVD)) |=> $stable(addr_q));
  // R3: no accepted grant, no load -> address frozen
  p_idle_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(addr_q));
endmodule

// File: rtl/xfc_count_core.sv
module xfc_count_core
  import xfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             grant,
  input  logic [CNT_W-1:0] init_cnt,
  output logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             adv,
  output logic             half_hit,
  output logic             last_hit,
  output logic             xfer_end
);
  logic [CNT_W-1:0] rem_q, half_q, rem_dec;
  logic             busy_q, half_seen_q, end_q;

  assign adv      = busy_q && grant && !load;
  assign rem_dec  = rem_q - CNT_W'(1);
  assign last_hit = adv && (rem_q == CNT_W'(1));
  assign half_hit = adv && !half_seen_q && (rem_dec == half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q       <= '0;
      half_q      <= '0;
      busy_q      <= 1'b0;
      half_seen_q <= 1'b0;
      end_q       <= 1'b0;
    end else begin
      end_q <= last_hit;
      if (load) begin
        rem_q       <= init_cnt;
        half_q      <= half_point(init_cnt);
        busy_q      <= 1'b1;
        half_seen_q <= 1'b0;
      end else if (adv) begin
        rem_q <= rem_dec;
        if (half_hit) half_seen_q <= 1'b1;
        if (last_hit) busy_q      <= 1'b0;
      end
    end
  end

  assign remaining = rem_q;
  assign busy      = busy_q;
  assign xfer_end  = end_q;

  // R3: one unit off per accepted grant
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grant && !load) |=> (remaining == $past(remaining) - CNT_W'(1)));
  // R3: idle grant ignored
  p_idle_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> ($stable(remaining) && !busy));
  // R7: last unit retires the run with a single end pulse
  p_end_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grant && !load && remaining == CNT_W'(1)) |=> (!busy && xfer_end));
  p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !xfer_end);
  // R2: load starts a run
  p_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/xfc_irq_flag.sv
module xfc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q & en;

  // R8: sticky until cleared, set beats clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
  import xfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_count,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [1:0]        load_unit,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic              grant,
  input  logic              half_ie,
  input  logic              done_ie,
  input  logic              half_clr,
  input  logic              done_clr,
  output logic              busy,
  output logic [CNT_W-1:0]  remaining,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              xfer_end,
  output logic              half_flag,
  output logic              done_flag,
  output logic              irq_half,
  output logic              irq_done
);
  localparam int N_FLAG = 2;  // index 0 halfway, 1 done

  logic adv, half_hit, last_hit;
  logic [N_FLAG-1:0] f_set, f_clr, f_en, f_flag, f_irq;
  logic [ADDR_W-1:0] a_init [2];
  logic [1:0]        a_mode [2];
  logic [ADDR_W-1:0] a_cur  [2];

  xfc_count_core u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .grant(grant), .init_cnt(load_count),
    .remaining(remaining), .busy(busy), .adv(adv), .half_hit(half_hit),
    .last_hit(last_hit), .xfer_end(xfer_end)
  );

  assign a_init[0] = load_src;
  assign a_init[1] = load_dst;
  assign a_mode[0] = src_mode;
  assign a_mode[1] = dst_mode;

  for (genvar g = 0; g < 2; g++) begin : g_addr
    xfc_addr_step u_step (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .init_addr(a_init[g]),
      .init_mode(a_mode[g]), .init_unit(load_unit), .addr(a_cur[g])
    );
  end

  assign src_addr = a_cur[0];
  assign dst_addr = a_cur[1];

  assign f_set = {last_hit, half_hit};
  assign f_clr = {done_clr, half_clr};
  assign f_en  = {done_ie, half_ie};

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    xfc_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(f_set[g]), .clr(f_clr[g]), .en(f_en[g]),
      .flag(f_flag[g]), .irq(f_irq[g])
    );
  end

  assign half_flag = f_flag[0];
  assign done_flag = f_flag[1];
  assign irq_half  = f_irq[0];
  assign irq_done  = f_irq[1];

  // R10: load and grant together -> the loaded count appears unchanged
  p_load_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && grant) |=> (remaining == $past(load_count)));
  // R7: completion flag accompanies the end pulse
  p_done_with_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> done_flag);
endmodule

// File: tb/sim_dma_xfer_count.sv
`timescale 1ns/1ps
module sim_dma_xfer_count;
  localparam time TCK = 20ns;

  logic clk = 0, rst_n = 0;
  logic load = 0, grant = 0, half_ie = 0, done_ie = 0, half_clr = 0, done_clr = 0;
  logic [23:0] load_count = 0;
  logic [31:0] load_src = 0, load_dst = 0;
  logic [1:0]  load_unit = 0, src_mode = 0, dst_mode = 0;
  logic busy, xfer_end, half_flag, done_flag, irq_half, irq_done;
  logic [23:0] remaining;
  logic [31:0] src_addr, dst_addr;

  int checks = 0, failures = 0;
  bit done_run = 0;

  // model state
  logic [24:0] m_rem = 0, m_half = 0;
  logic        m_busy = 0, m_hseen = 0, m_hf = 0, m_df = 0, m_end = 0;
  logic [31:0] m_src = 0, m_dst = 0;
  logic [1:0]  m_unit = 0, m_sm = 0, m_dm = 0;

  always #(TCK/2) clk = ~clk;

  dma_xfer_count u0 (.*);

  function automatic logic [31:0] bstep(logic [1:0] u);
    return (u == 2'd3) ? 32'd16 : (32'd1 << u);
  endfunction

  function automatic logic [31:0] mv(logic [31:0] a, logic [1:0] m, logic [1:0] u);
    if (m == 2'd1) return a + bstep(u);
    if (m == 2'd2) return a - bstep(u);
    return a;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 remaining", 64'(remaining), 64'(m_rem[23:0]));
    chk("R2 busy", 64'(busy), 64'(m_busy));
    chk("R4 src_addr", 64'(src_addr), 64'(m_src));
    chk("R4 dst_addr", 64'(dst_addr), 64'(m_dst));
    chk("R7 xfer_end", 64'(xfer_end), 64'(m_end));
    chk("R6 half_flag", 64'(half_flag), 64'(m_hf));
    chk("R7 done_flag", 64'(done_flag), 64'(m_df));
    chk("R9 irq_half", 64'(irq_half), 64'(m_hf & half_ie));
    chk("R9 irq_done", 64'(irq_done), 64'(m_df & done_ie));
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input logic ld, input logic [23:0] c, input logic [31:0] s, input logic [31:0] d,
                     input logic [1:0] u, input logic [1:0] sm, input logic [1:0] dm,
                     input logic gr, input logic hc, input logic dc);
    logic hit_h, hit_d;
    load = ld; load_count = c; load_src = s; load_dst = d; load_unit = u;
    src_mode = sm; dst_mode = dm; grant = gr; half_clr = hc; done_clr = dc;
    @(posedge clk);
    hit_h = 0; hit_d = 0; m_end = 0;
    if (ld) begin
      m_rem = (c == 0) ? 25'h100_0000 : {1'b0, c};
      m_half = m_rem / 2;
      m_hseen = 0; m_busy = 1;
      m_src = s; m_dst = d; m_unit = u; m_sm = sm; m_dm = dm;
    end else if (gr && m_busy) begin
      m_rem = m_rem - 1;
      m_src = mv(m_src, m_sm, m_unit);
      m_dst = mv(m_dst, m_dm, m_unit);
      if (!m_hseen && m_rem == m_half) begin hit_h = 1; m_hseen = 1; end
      if (m_rem == 0) begin hit_d = 1; m_busy = 0; m_end = 1; end
    end
    m_hf = hit_h ? 1'b1 : (hc ? 1'b0 : m_hf);
    m_df = hit_d ? 1'b1 : (dc ? 1'b0 : m_df);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input logic gr);
    cyc(0, 0, 0, 0, 0, 0, 0, gr, 0, 0);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 remaining", 64'(remaining), 0);
    chk("R1 src/dst", {src_addr, dst_addr}, 0);
    chk("R1 flags", {xfer_end, half_flag, done_flag, irq_half, irq_done}, 0);

    half_ie = 1; done_ie = 1;
    // R3 grant while idle ignored
    idle(1); idle(1);
    // R2/R4/R6/R7 directed: 4 words, src up, dst down
    cyc(1, 24'd4, 32'h100, 32'h2000, 2'd1, 2'd1, 2'd2, 0, 0, 0);
    chk("R2 loaded remaining", 64'(remaining), 4);
    repeat (4) idle(1);
    chk("R4 src after 4 words", 64'(src_addr), 64'h108);
    chk("R4 dst after 4 words", 64'(dst_addr), 64'h1ff8);
    chk("R6 half set", 64'(half_flag), 1);
    chk("R7 done set busy low", {busy, done_flag}, 64'b01);
    idle(0);
    chk("R7 end pulse one cycle", 64'(xfer_end), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R8 cleared", {half_flag, done_flag}, 0);

    // R5 count zero is the maximum
    cyc(1, 24'd0, 32'h0, 32'h0, 2'd3, 2'd1, 2'd3, 0, 0, 0);
    idle(1);
    chk("R5 remaining after one grant", 64'(remaining), 64'hFFFFFF);
    chk("R5 still busy, no half", {busy, half_flag}, 64'b10);
    chk("R4 16-byte step", {src_addr, dst_addr}, {32'h10, 32'h0});

    // R10 load together with grant
    cyc(1, 24'd3, 32'hFFFF_FFFC, 32'h4, 2'd2, 2'd1, 2'd2, 1, 0, 0);
    chk("R10 load wins", 64'(remaining), 3);
    // R4 wraparound both ways
    idle(1);
    chk("R4 wrap up/down", {src_addr, dst_addr}, {32'h0, 32'h0});
    idle(1); idle(1);

    // R8 set and clear in the same cycle: count 2, half on first grant
    cyc(1, 24'd2, 32'h0, 32'h0, 2'd0, 2'd0, 2'd0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R8 set beats clear", 64'(half_flag), 1);
    // R9 disabled flag held, request low
    half_ie = 0;
    idle(0);
    chk("R9 gated request", {half_flag, irq_half}, 64'b10);
    half_ie = 1;
    idle(1);
    // R6 single unit run sets both on the last grant
    cyc(1, 24'd1, 32'h0, 32'h0, 2'd0, 2'd0, 2'd0, 0, 1, 1);
    idle(1);
    chk("R6 half on final grant", {half_flag, done_flag}, 64'b11);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] c;
      int r = $urandom_range(0, 99);
      if (r < 70) c = 24'($urandom_range(1, 20));
      else if (r < 92) c = 24'($urandom_range(21, 300));
      else if (r < 96) c = 24'd0;
      else c = 24'($urandom);
      if ($urandom_range(0, 49) == 0) half_ie = ~half_ie;
      if ($urandom_range(0, 49) == 0) done_ie = ~done_ie;
      cyc(($urandom_range(0, 59) == 0) || (!m_busy && $urandom_range(0, 3) == 0),
          c, $urandom, $urandom, 2'($urandom), 2'($urandom), 2'($urandom),
          $urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end
    finish_run();
  end
endmodule